// File: doc/BRIEF.md
# I2C Controller Register and Interrupt Front-End

This block is the software-visible face of an I2C master. It accepts 32-bit register reads and writes at word-aligned offsets. It buffers transfer commands for a byte engine and buffers the bytes that engine receives. It also holds the control word and the three bus timing counts. The bit-level signalling on the wire happens elsewhere: the byte engine pulls commands from this block, pushes received bytes into it and reports bus events back to it.

Interrupt causes are kept in a latching status register. Each bit is cleared by writing one to it. A mask register decides which causes drive the single level-sensitive interrupt line. The two "ready" causes follow programmable FIFO thresholds, so software can choose how full or empty a FIFO gets before it is asked to act.

Top module: `i2c_csr_front`

## Requirements
- R1: A write to offset 0x00 pushes write-data bits 9:0 into the command FIFO. The engine sees the entries oldest first on `eng_cmd_data`, with `eng_cmd_valid` high while the FIFO is not empty. Offset 0x18 reads the current command FIFO occupancy.
- R2: A write to offset 0x00 while the command FIFO holds CMD_DEPTH entries is dropped: the occupancy and the stored entries stay as they were.
- R3: A byte pushed by the engine enters the receive FIFO. A read of offset 0x04 returns the oldest byte in bits 7:0 and removes it, or returns 0 when the FIFO is empty. Offset 0x1C reads the receive occupancy.
- R4: A byte that arrives while the receive FIFO is full is discarded and status bit 4 (receive overflow) is set.
- R5: Status bit 0 (transmit ready) is set in every cycle in which the command occupancy is at most the command threshold in control bits 3:2.
- R6: Status bit 1 (receive ready) is set in every cycle in which the receive occupancy is at least the receive threshold in control bits 5:4 plus one.
- R7: An engine NACK pulse sets status bit 2, and an engine arbitration-loss pulse sets status bit 3. Both bits hold until they are cleared.
- R8: Writing offset 0x10 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A set condition in the same cycle wins.
- R9: `irq` is high exactly when some status bit and the same bit of the enable register at offset 0x0C (same layout) are both 1.
- R10: Control bit 0 drives `core_en` and bit 1 drives `fast_mode`. Offsets 0x20, 0x24 and 0x28 hold the SCL low, SCL high and SDA hold counts and drive the matching outputs. All of these read back what was written.
- R11: Bit 0 of offset 0x14 reads 1 while `eng_busy` is high and 0 otherwise.
- R12: After reset, all registers and FIFOs are empty or zero, and `irq` is low. Read data appears in `rdata` on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| eng_cmd_data | output | 10 | Head of command FIFO |
| eng_cmd_valid | output | 1 | Command FIFO not empty |
| eng_cmd_pop | input | 1 | Engine takes the head command |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_nack | input | 1 | NACK event pulse |
| eng_arb_lost | input | 1 | Arbitration-loss event pulse |
| eng_busy | input | 1 | Transfer in progress |
| core_en | output | 1 | Core enable |
| fast_mode | output | 1 | Fast bus speed select |
| scl_low_cnt | output | CNT_W | SCL low count |
| scl_high_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |

## Verification
The FIFOs are driven by a seeded random mix of command writes, engine pops, engine byte deliveries and data reads. A queue model in the bench predicts each head value and occupancy, which catches ordering and pointer-wrap faults. Directed sequences then fill each FIFO past its depth, which separates a dropped entry from an overwritten one. Threshold settings are chosen so that the ready bits sit just above and just below their trigger level, which exposes an off-by-one in the threshold comparison. Event pulses, selective clear writes and mask settings separate latching, clearing and interrupt gating from one another.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int CMD_W  = 10;
    localparam int IRQ_N  = 5;
    localparam int THR_W  = 2;

    localparam int B_TXRDY = 0;
    localparam int B_RXRDY = 1;
    localparam int B_NACK  = 2;
    localparam int B_ARB   = 3;
    localparam int B_RXOVF = 4;

    localparam int W_CMD    = 0;
    localparam int W_RXDATA = 1;
    localparam int W_CTRL   = 2;
    localparam int W_IEN    = 3;
    localparam int W_ISTAT  = 4;
    localparam int W_CORE   = 5;
    localparam int W_CMDLVL = 6;
    localparam int W_RXLVL  = 7;
    localparam int W_SCLLO  = 8;
    localparam int W_SCLHI  = 9;
    localparam int W_HOLD   = 10;

    typedef logic [IRQ_N-1:0] irq_vec_t;

    typedef struct packed {
        logic [THR_W-1:0] rx_thr;
        logic [THR_W-1:0] cmd_thr;
        logic             fast;
        logic             en;
    } ctrl_t;

    function automatic logic tx_ready(input int level, input int thr);
        return level <= thr;
    endfunction

    function automatic logic rx_ready(input int level, input int thr);
        return level >= thr + 1;
    endfunction

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_ok) rd_ptr <= nxt(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level == LVL_W'(DEPTH)));

endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq
    import i2cf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_vec,
    input  irq_vec_t clr_vec,
    input  irq_vec_t en_vec,
    output irq_vec_t status,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_vec) | set_vec;
    end

    assign irq = |(status & en_vec);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

    assert_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_vec == '0) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/i2c_csr_front.sv
module i2c_csr_front
    import i2cf_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int RX_DEPTH  = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic [9:0]        eng_cmd_data,
    output logic              eng_cmd_valid,
    input  logic              eng_cmd_pop,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_nack,
    input  logic              eng_arb_lost,
    input  logic              eng_busy,
    output logic              core_en,
    output logic              fast_mode,
    output logic [CNT_W-1:0]  scl_low_cnt,
    output logic [CNT_W-1:0]  scl_high_cnt,
    output logic [CNT_W-1:0]  sda_hold_cnt
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int CMD_LVL_W = $clog2(CMD_DEPTH + 1);
    localparam int RX_LVL_W  = $clog2(RX_DEPTH + 1);

    logic [WORD_W-1:0]    word;
    ctrl_t                ctrl;
    irq_vec_t             ien, status, set_vec, clr_vec;
    logic                 cmd_push, cmd_full, cmd_empty;
    logic [CMD_LVL_W-1:0] cmd_level;
    logic                 rx_pop, rx_full, rx_empty;
    logic [RX_LVL_W-1:0]  rx_level;
    logic [7:0]           rx_head;
    logic [31:0]          rd_mux;

    assign word     = addr[ADDR_W-1:2];
    assign cmd_push = wr_en && (word == WORD_W'(W_CMD));
    assign rx_pop   = rd_en && (word == WORD_W'(W_RXDATA));

    i2cf_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_push),
        .din   (wdata[CMD_W-1:0]),
        .pop   (eng_cmd_pop),
        .dout  (eng_cmd_data),
        .full  (cmd_full),
        .empty (cmd_empty),
        .level (cmd_level)
    );

    i2cf_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_rx_valid),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    assign eng_cmd_valid = !cmd_empty;

    always_comb begin
        set_vec          = '0;
        set_vec[B_TXRDY] = tx_ready(int'(cmd_level), int'(ctrl.cmd_thr));
        set_vec[B_RXRDY] = rx_ready(int'(rx_level), int'(ctrl.rx_thr));
        set_vec[B_NACK]  = eng_nack;
        set_vec[B_ARB]   = eng_arb_lost;
        set_vec[B_RXOVF] = eng_rx_valid && rx_full;
        clr_vec = (wr_en && (word == WORD_W'(W_ISTAT))) ? wdata[IRQ_N-1:0] : '0;
    end

    i2cf_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (ien),
        .status  (status),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl         <= '0;
            ien          <= '0;
            scl_low_cnt  <= '0;
            scl_high_cnt <= '0;
            sda_hold_cnt <= '0;
        end else if (wr_en) begin
            case (word)
                WORD_W'(W_CTRL):  ctrl         <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
                WORD_W'(W_IEN):   ien          <= wdata[IRQ_N-1:0];
                WORD_W'(W_SCLLO): scl_low_cnt  <= wdata[CNT_W-1:0];
                WORD_W'(W_SCLHI): scl_high_cnt <= wdata[CNT_W-1:0];
                WORD_W'(W_HOLD):  sda_hold_cnt <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign core_en   = ctrl.en;
    assign fast_mode = ctrl.fast;

    always_comb begin
        rd_mux = '0;
        case (word)
            WORD_W'(W_RXDATA): rd_mux = rx_empty ? '0 : 32'(rx_head);
            WORD_W'(W_CTRL):   rd_mux = 32'(ctrl);
            WORD_W'(W_IEN):    rd_mux = 32'(ien);
            WORD_W'(W_ISTAT):  rd_mux = 32'(status);
            WORD_W'(W_CORE):   rd_mux = 32'(eng_busy);
            WORD_W'(W_CMDLVL): rd_mux = 32'(cmd_level);
            WORD_W'(W_RXLVL):  rd_mux = 32'(rx_level);
            WORD_W'(W_SCLLO):  rd_mux = 32'(scl_low_cnt);
            WORD_W'(W_SCLHI):  rd_mux = 32'(scl_high_cnt);
            WORD_W'(W_HOLD):   rd_mux = 32'(sda_hold_cnt);
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_rx_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_valid && rx_full && !rx_pop) |=>
            (status[B_RXOVF] && rx_level == RX_LVL_W'(RX_DEPTH)));

    assert_txrdy_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(cmd_level) <= int'(ctrl.cmd_thr)) |=> status[B_TXRDY]);

    assert_rxrdy_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_level) > int'(ctrl.rx_thr)) |=> status[B_RXRDY]);

    assert_valid_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_push && cmd_empty && !eng_cmd_pop) |=> eng_cmd_valid);

endmodule

// File: tb/i2c_csr_front_tb.sv
`timescale 1ns/1ps
module i2c_csr_front_tb;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [9:0]  eng_cmd_data;
    logic        eng_cmd_valid;
    logic        eng_cmd_pop = 1'b0;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_nack = 1'b0, eng_arb_lost = 1'b0, eng_busy = 1'b0;
    logic        core_en, fast_mode;
    logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_csr_front u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .eng_cmd_data(eng_cmd_data), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd_pop(eng_cmd_pop), .eng_rx_valid(eng_rx_valid),
        .eng_rx_data(eng_rx_data), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_busy(eng_busy),
        .core_en(core_en), .fast_mode(fast_mode),
        .scl_low_cnt(scl_low_cnt), .scl_high_cnt(scl_high_cnt),
        .sda_hold_cnt(sda_hold_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_tx(input int lvl, input int thr);
        return lvl <= thr;
    endfunction

    function automatic logic exp_rx(input int lvl, input int thr);
        return lvl >= thr + 1;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic eng_pop();
        @(negedge clk);
        eng_cmd_pop = 1'b1;
        @(negedge clk);
        eng_cmd_pop = 1'b0;
    endtask

    task automatic eng_rx(input logic [7:0] b);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic pulse(input bit is_arb);
        @(negedge clk);
        if (is_arb) eng_arb_lost = 1'b1; else eng_nack = 1'b1;
        @(negedge clk);
        eng_arb_lost = 1'b0; eng_nack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [9:0]  cq[$];
        logic [7:0]  rq[$];
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 irq", 32'(irq), 0);
        check("R12 core_en", 32'(core_en), 0);
        check("R12 counts", 32'(scl_low_cnt | scl_high_cnt | sda_hold_cnt), 0);
        check("R12 cmd valid", 32'(eng_cmd_valid), 0);
        rst = 1'b0;
        idle(2);
        rd(6'h10, d); check("R12 R5 status after reset", d, 32'h1);
        rd(6'h18, d); check("R12 cmd level", d, 0);
        rd(6'h1C, d); check("R12 rx level", d, 0);

        // R1 ordering and level
        wr(6'h00, 32'h2A5);
        wr(6'h00, 32'hFFFF_F13C);
        rd(6'h18, d); check("R1 cmd level 2", d, 2);
        @(negedge clk);
        check("R1 head 1", 32'(eng_cmd_data), 32'h2A5);
        eng_pop();
        check("R1 head 2", 32'(eng_cmd_data), 32'h13C);
        eng_pop();
        check("R1 valid low", 32'(eng_cmd_valid), 0);

        // R2 write when full dropped
        for (int i = 0; i < DEPTH + 1; i++) wr(6'h00, 32'h10 + i);
        rd(6'h18, d); check("R2 level full", d, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            check("R2 contents", 32'(eng_cmd_data), 32'h10 + i);
            eng_pop();
        end
        rd(6'h18, d); check("R2 level empty", d, 0);

        // R5 / R6 thresholds: cmd thr 1, rx thr 1
        wr(6'h08, 32'h14);
        wr(6'h00, 32'h1); wr(6'h00, 32'h2);
        wr(6'h10, 32'h1F); idle(2);
        rd(6'h10, d); check("R5 level2 thr1", d & 1, 32'(exp_tx(2, 1)));
        eng_pop(); idle(2);
        rd(6'h10, d); check("R5 level1 thr1", d & 1, 32'(exp_tx(1, 1)));
        eng_pop();
        eng_rx(8'h11);
        wr(6'h10, 32'h1F); idle(2);
        rd(6'h10, d); check("R6 level1 thr1", (d >> 1) & 1, 32'(exp_rx(1, 1)));
        eng_rx(8'h22); idle(2);
        rd(6'h10, d); check("R6 level2 thr1", (d >> 1) & 1, 32'(exp_rx(2, 1)));
        rd(6'h04, d); check("R3 pop first", d, 32'h11);
        rd(6'h04, d); check("R3 pop second", d, 32'h22);
        rd(6'h04, d); check("R3 empty read", d, 0);

        // R4 overflow
        wr(6'h10, 32'h1F);
        for (int i = 0; i < DEPTH + 1; i++) eng_rx(8'hA0 + 8'(i));
        rd(6'h1C, d); check("R4 level", d, DEPTH);
        rd(6'h10, d); check("R4 ovf bit", (d >> 4) & 1, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(6'h04, d); check("R4 kept bytes", d, 32'hA0 + i);
        end
        rd(6'h1C, d); check("R4 drained", d, 0);

        // R7 R8 R9
        wr(6'h08, 32'h0);
        wr(6'h10, 32'h1F);
        wr(6'h0C, 32'h04);
        idle(1); check("R9 irq quiet", 32'(irq), 0);
        pulse(1'b0); pulse(1'b1); idle(1);
        check("R9 irq on nack", 32'(irq), 1);
        rd(6'h10, d); check("R7 nack arb latched", d & 32'h0C, 32'h0C);
        wr(6'h10, 32'h08); idle(1);
        rd(6'h10, d); check("R8 selective clear", d & 32'h0C, 32'h04);
        check("R9 irq still on", 32'(irq), 1);
        wr(6'h10, 32'h04); idle(1);
        check("R9 irq off", 32'(irq), 0);
        wr(6'h0C, 32'h01); idle(1);
        check("R9 txrdy irq", 32'(irq), 1);
        wr(6'h0C, 32'h00);

        // R10 R11
        wr(6'h08, 32'h03);
        check("R10 core_en", 32'(core_en), 1);
        check("R10 fast_mode", 32'(fast_mode), 1);
        rd(6'h08, d); check("R10 ctrl readback", d, 3);
        wr(6'h20, 32'h1234); wr(6'h24, 32'h0567); wr(6'h28, 32'h0089);
        check("R10 scl low port", 32'(scl_low_cnt), 32'h1234);
        check("R10 scl high port", 32'(scl_high_cnt), 32'h0567);
        check("R10 hold port", 32'(sda_hold_cnt), 32'h0089);
        rd(6'h24, d); check("R10 scl high readback", d, 32'h0567);
        eng_busy = 1'b1;
        rd(6'h14, d); check("R11 busy", d, 1);
        eng_busy = 1'b0;
        rd(6'h14, d); check("R11 idle", d, 0);

        // random mix, R1 R3
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: begin
                    logic [9:0] v;
                    v = 10'($urandom);
                    wr(6'h00, 32'(v));
                    if (cq.size() < DEPTH) cq.push_back(v);
                end
                1: begin
                    @(negedge clk);
                    check("R1 random valid", 32'(eng_cmd_valid), 32'(cq.size() != 0));
                    if (cq.size() != 0) begin
                        check("R1 random head", 32'(eng_cmd_data), 32'(cq[0]));
                        void'(cq.pop_front());
                    end
                    eng_pop();
                end
                2: begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    eng_rx(b);
                    if (rq.size() < DEPTH) rq.push_back(b);
                end
                default: begin
                    logic [31:0] e;
                    e = (rq.size() != 0) ? 32'(rq.pop_front()) : 32'h0;
                    rd(6'h04, d); check("R3 random data", d, e);
                end
            endcase
            if (it % 16 == 15) begin
                rd(6'h18, d); check("R1 random cmd level", d, cq.size());
                rd(6'h1C, d); check("R3 random rx level", d, rq.size());
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule